// File: doc/BRIEF.md
# Banked GPIO Register Controller

The controller exposes a parameterised number of general-purpose pins, up to 96 and 76 by default, through a small register space. It uses a single-cycle 32-bit access port. Pins are grouped in banks of 32. Each bank has three registers:

- **Use-select:** chooses between GPIO and the pin's native function.
- **Direction:** sets each pin as input or output.
- **Level:** holds the output value, or returns the sampled input.

Some pins can only be inputs and some can only be outputs. A write that tries to move such a pin to the other direction leaves its direction bit unchanged. Software can therefore read the register back to find out whether the change took effect.

A second, power-management register space holds one sticky change flag for each of the lowest sixteen inputs. Software clears a flag by writing 1 to it. A global enable input gates every output enable, and it also locks the use-select registers.

The access port is a plain strobe interface with no back-pressure. Every access completes in the cycle it is presented. A read returns its data, with `rd_valid` high, on the following cycle.

Top module: `gpio_banked_ctrl`

## Requirements
- R1: After reset:
  - use-select holds the `USE_RST_MASK` value of implemented pins;
  - each direction bit is 1 (input), except on output-only pins, where it is 0;
  - levels are 0;
  - the change flags are clear.
- R2: Register mapping and read timing:
  - Pin n lives in bank n/32 at bit n mod 32.
  - GPIO-space byte offsets are 0x00/0x30/0x40 for use-select, 0x04/0x34/0x44 for direction and 0x0C/0x38/0x48 for level, for banks 0/1/2.
  - A read presented in one cycle returns its data with `rd_valid` high on the next cycle.
- R3: A direction bit of 1 means input and 0 means output. A write leaves the bit at 1 on input-only pins and at 0 on output-only pins. When a pin is in both masks, input wins.
- R4: Register bits for pins at or above `NPINS` read as 0, and writes to them have no effect.
- R5: Output drive:
  - `pin_out[n]` equals level bit n.
  - `pin_oe[n]` is 1 only when the enable is high, use-select bit n is 1 (GPIO; 0 selects the native function) and direction bit n is 0.
- R6: A level read returns, for each output pin, the stored level. For each input pin it returns `pin_in` after a two-flop synchronizer, so a change is visible to reads from the third clock edge onward.
- R7: In power-management space, offset 0x28 bit 16+n (n < 16) is set by a change of synchronised input n and stays set. Inputs 16 and above never set a flag, and the other bits read 0.
- R8: Clearing the change flags:
  - Writing 1 to bit 16+n at PM offset 0x28 clears flag n.
  - Writing 0 leaves the flag as it is.
  - When a change and a clear of the same flag meet in one cycle, the flag stays set.
- R9: While `func_en` is 0, `pin_oe` is all zero and writes to use-select registers are ignored.
- R10: The decoded window is 128 bytes when `NPINS` > 64, and 64 bytes otherwise. In the 64-byte case, address bit 6 is ignored, so 0x44 reaches the same register as 0x04.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| func_en | input | 1 | Global GPIO function enable |
| acc_valid | input | 1 | Access strobe, completes in the same cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_pm | input | 1 | 1 = power-management space, 0 = GPIO space |
| acc_addr | input | 7 | Byte offset |
| acc_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after the read strobe |
| rd_data | output | 32 | Read data |
| pin_in | input | NPINS | Pad input values |
| pin_out | output | NPINS | Pad output values |
| pin_oe | output | NPINS | Pad output enables |

## Verification
Several properties are checked on every cycle:
- the enable gating of `pin_oe`;
- that input-only pins are never driven;
- that a change flag can only drop in a cycle that follows a power-management write;
- that the use-select state is frozen while disabled;
- that `rd_valid` follows a read strobe.

Other behaviours can only be shown by the bench scenarios, because they depend on register values:
- the bank and offset mapping;
- the clamping of fixed-direction bits;
- the reading of unimplemented bits as zero;
- synchronizer latency;
- the same-cycle set-over-clear race;
- address aliasing in a 64-byte window.

The bench sweeps data patterns through all nine registers of a 76-pin instance and checks the window on a second, 20-pin instance.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int MAX_BANKS = 3;
  localparam int BANK_BITS = 32;
  localparam int MAX_PINS  = MAX_BANKS * BANK_BITS;
  localparam int PM_SHIFT  = 16;
  localparam int PM_FLAGS  = 16;
  localparam logic [6:0] PM_STATUS_OFS = 7'h28;

  typedef enum logic [1:0] {
    KIND_USE = 2'd0,
    KIND_DIR = 2'd1,
    KIND_LVL = 2'd2
  } reg_kind_e;

  // Byte offset of a bank register; software depends on these positions.
  function automatic logic [6:0] reg_offset(reg_kind_e kind, int bank);
    logic [6:0] ofs;
    case (bank)
      0: ofs = (kind == KIND_USE) ? 7'h00 : (kind == KIND_DIR) ? 7'h04 : 7'h0C;
      1: ofs = (kind == KIND_USE) ? 7'h30 : (kind == KIND_DIR) ? 7'h34 : 7'h38;
      default: ofs = (kind == KIND_USE) ? 7'h40 : (kind == KIND_DIR) ? 7'h44 : 7'h48;
    endcase
    return ofs;
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W    = 76,
  parameter int NCHG = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    d,
  output logic [W-1:0]    q,
  output logic [NCHG-1:0] chg
);
  logic [W-1:0]    meta_q;
  logic [NCHG-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
      prev_q <= q[NCHG-1:0];
    end
  end

  assign chg = q[NCHG-1:0] ^ prev_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int          BANK_W   = 32,
  parameter logic [31:0] IN_ONLY  = 32'h0,
  parameter logic [31:0] OUT_ONLY = 32'h0,
  parameter logic [31:0] USE_RST  = 32'hFFFF_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        func_en,
  input  logic        wr_use,
  input  logic        wr_dir,
  input  logic        wr_lvl,
  input  logic [31:0] wdata,
  input  logic [31:0] pin_sync,
  output logic [31:0] use_q,
  output logic [31:0] dir_q,
  output logic [31:0] lvl_q,
  output logic [31:0] lvl_view
);
  localparam logic [31:0] IMPL    = (BANK_W >= 32) ? 32'hFFFF_FFFF
                                                   : ((32'd1 << BANK_W) - 32'd1);
  localparam logic [31:0] DIR_RST = ((IMPL & ~OUT_ONLY) | IN_ONLY) & IMPL;

  logic [31:0] dir_w;
  assign dir_w = ((wdata & ~OUT_ONLY) | IN_ONLY) & IMPL;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      use_q <= USE_RST & IMPL;
      dir_q <= DIR_RST;
      lvl_q <= '0;
    end else begin
      if (wr_use && func_en) use_q <= wdata & IMPL;
      if (wr_dir)            dir_q <= dir_w;
      if (wr_lvl)            lvl_q <= wdata & IMPL;
    end
  end

  assign lvl_view = ((lvl_q & ~dir_q) | (pin_sync & dir_q)) & IMPL;
endmodule

// File: rtl/gpio_pm_status.sv
module gpio_pm_status #(
  parameter int NLOW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLOW-1:0] chg,
  input  logic            clr_en,
  input  logic [NLOW-1:0] clr_bits,
  output logic [NLOW-1:0] st_q
);
  logic [NLOW-1:0] clr_mask;
  assign clr_mask = clr_en ? clr_bits : '0;

  // A change arriving in the same cycle as a clear keeps the flag set.
  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= (st_q & ~clr_mask) | chg;
  end
endmodule

// File: rtl/gpio_banked_ctrl.sv
module gpio_banked_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int          NPINS        = 76,
  parameter logic [95:0] IN_ONLY_MASK = 96'h0,
  parameter logic [95:0] OUT_ONLY_MASK = 96'h0,
  parameter logic [95:0] USE_RST_MASK = {96{1'b1}}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             func_en,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic             acc_pm,
  input  logic [6:0]       acc_addr,
  input  logic [31:0]      acc_wdata,
  output logic             rd_valid,
  output logic [31:0]      rd_data,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe
);
  localparam int NBANKS   = (NPINS + BANK_BITS - 1) / BANK_BITS;
  localparam int PAD      = NBANKS * BANK_BITS;
  localparam int WIN_BITS = (NPINS > 64) ? 7 : 6;
  localparam logic [6:0] WIN_MASK = 7'((1 << WIN_BITS) - 1);
  localparam int NLOW     = (NPINS < PM_FLAGS) ? NPINS : PM_FLAGS;

  logic [6:0]       off;
  logic [NPINS-1:0] sync_q;
  logic [PAD-1:0]   sync_pad;
  logic [NLOW-1:0]  chg;
  logic [NLOW-1:0]  st_q;
  logic [PAD-1:0]   use_all, dir_all, lvl_all, view_all;
  logic             gpio_wr, pm_clr;
  logic [31:0]      rsel;

  assign off     = acc_addr & WIN_MASK;
  assign gpio_wr = acc_valid && acc_write && !acc_pm;
  assign pm_clr  = acc_valid && acc_write && acc_pm && (off == PM_STATUS_OFS);

  gpio_in_sync #(.W(NPINS), .NCHG(NLOW)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_q), .chg(chg)
  );

  always_comb begin
    sync_pad = '0;
    sync_pad[NPINS-1:0] = sync_q;
  end

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    localparam int BW = ((NPINS - BANK_BITS * b) >= BANK_BITS) ? BANK_BITS
                                                               : (NPINS - BANK_BITS * b);
    gpio_bank #(
      .BANK_W  (BW),
      .IN_ONLY (IN_ONLY_MASK[BANK_BITS*b +: BANK_BITS]),
      .OUT_ONLY(OUT_ONLY_MASK[BANK_BITS*b +: BANK_BITS]),
      .USE_RST (USE_RST_MASK[BANK_BITS*b +: BANK_BITS])
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .func_en (func_en),
      .wr_use  (gpio_wr && (off == reg_offset(KIND_USE, b))),
      .wr_dir  (gpio_wr && (off == reg_offset(KIND_DIR, b))),
      .wr_lvl  (gpio_wr && (off == reg_offset(KIND_LVL, b))),
      .wdata   (acc_wdata),
      .pin_sync(sync_pad[BANK_BITS*b +: BANK_BITS]),
      .use_q   (use_all[BANK_BITS*b +: BANK_BITS]),
      .dir_q   (dir_all[BANK_BITS*b +: BANK_BITS]),
      .lvl_q   (lvl_all[BANK_BITS*b +: BANK_BITS]),
      .lvl_view(view_all[BANK_BITS*b +: BANK_BITS])
    );
  end

  gpio_pm_status #(.NLOW(NLOW)) u_pm (
    .clk     (clk),
    .rst_n   (rst_n),
    .chg     (chg),
    .clr_en  (pm_clr),
    .clr_bits(acc_wdata[PM_SHIFT +: NLOW]),
    .st_q    (st_q)
  );

  always_comb begin
    rsel = '0;
    if (acc_pm) begin
      if (off == PM_STATUS_OFS) rsel = 32'(st_q) << PM_SHIFT;
    end else begin
      for (int b = 0; b < NBANKS; b++) begin
        if (off == reg_offset(KIND_USE, b)) rsel = use_all[BANK_BITS*b +: BANK_BITS];
        if (off == reg_offset(KIND_DIR, b)) rsel = dir_all[BANK_BITS*b +: BANK_BITS];
        if (off == reg_offset(KIND_LVL, b)) rsel = view_all[BANK_BITS*b +: BANK_BITS];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= acc_valid && !acc_write;
      if (acc_valid && !acc_write) rd_data <= rsel;
    end
  end

  assign pin_out = lvl_all[NPINS-1:0];
  assign pin_oe  = func_en ? (use_all[NPINS-1:0] & ~dir_all[NPINS-1:0]) : '0;
endmodule

// File: rtl/gpio_banked_ctrl_chk.sv
module gpio_banked_ctrl_chk #(
  parameter int          NPINS        = 76,
  parameter int          PAD          = 96,
  parameter int          NLOW         = 16,
  parameter logic [95:0] IN_ONLY_MASK = 96'h0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             func_en,
  input logic             acc_valid,
  input logic             acc_write,
  input logic             acc_pm,
  input logic             rd_valid,
  input logic [NPINS-1:0] pin_oe,
  input logic [NLOW-1:0]  st_q,
  input logic [PAD-1:0]   use_all
);
  assert_oe_quiet_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !func_en |-> (pin_oe == '0));

  assert_in_only_never_driven_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & IN_ONLY_MASK[NPINS-1:0]) == '0);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(acc_valid && acc_write && acc_pm) |-> (($past(st_q) & ~st_q) == '0));

  assert_read_follows_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(acc_valid && !acc_write));

  assert_use_frozen_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(func_en) |-> $stable(use_all));
endmodule

bind gpio_banked_ctrl gpio_banked_ctrl_chk #(
  .NPINS(NPINS), .PAD(PAD), .NLOW(NLOW), .IN_ONLY_MASK(IN_ONLY_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .func_en(func_en), .acc_valid(acc_valid),
  .acc_write(acc_write), .acc_pm(acc_pm), .rd_valid(rd_valid),
  .pin_oe(pin_oe), .st_q(st_q), .use_all(use_all)
);

// File: tb/gpio_banked_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_banked_ctrl_bench;
  localparam logic [31:0] IMPL [3] = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0FFF};
  localparam logic [31:0] INO  [3] = '{32'h0000_0008, 32'h0000_0100, 32'h0000_0040};
  localparam logic [31:0] OUTO [3] = '{32'h0000_0020, 32'h0000_0200, 32'h0000_0080};
  localparam logic [31:0] URST [3] = '{32'hFFFF_0F0F, 32'h1234_5678, 32'hFFFF_FABC};
  localparam logic [31:0] PATS [5] = '{32'hFFFF_FFFF, 32'h0000_0000, 32'hA5A5_A5A5,
                                       32'h5A5A_5A5A, 32'h1357_9BDF};

  logic clk = 0, rst_n = 0, func_en = 1;
  logic acc_write = 0, acc_pm = 0, valid_m = 0, valid_s = 0;
  logic [6:0] acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic [95:0] pins = '0;
  logic rdv_m, rdv_s;
  logic [31:0] rd_m, rd_s;
  logic [75:0] pout_m, poe_m;
  logic [19:0] pout_s, poe_s;
  logic [31:0] m_use [3], m_dir [3], m_lvl [3];
  int nchk = 0, nerr = 0, cyc = 0;
  logic [31:0] q;

  always #4 clk = ~clk;

  gpio_banked_ctrl #(
    .NPINS(76),
    .IN_ONLY_MASK({INO[2], INO[1], INO[0]}),
    .OUT_ONLY_MASK({OUTO[2], OUTO[1], OUTO[0]}),
    .USE_RST_MASK({URST[2], URST[1], URST[0]})
  ) u_gpio_banked_ctrl (
    .clk(clk), .rst_n(rst_n), .func_en(func_en), .acc_valid(valid_m),
    .acc_write(acc_write), .acc_pm(acc_pm), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rd_valid(rdv_m), .rd_data(rd_m), .pin_in(pins[75:0]), .pin_out(pout_m), .pin_oe(poe_m)
  );

  gpio_banked_ctrl #(.NPINS(20)) u_gpio_banked_ctrl_small (
    .clk(clk), .rst_n(rst_n), .func_en(func_en), .acc_valid(valid_s),
    .acc_write(acc_write), .acc_pm(acc_pm), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rd_valid(rdv_s), .rd_data(rd_s), .pin_in(pins[19:0]), .pin_out(pout_s), .pin_oe(poe_s)
  );

  function automatic logic [6:0] ofs(int kind, int b);
    logic [6:0] base [3] = '{7'h00, 7'h30, 7'h40};
    logic [6:0] d0 [3] = '{7'h00, 7'h04, 7'h0C};
    logic [6:0] d12 [3] = '{7'h00, 7'h04, 7'h08};
    return base[b] + ((b == 0) ? d0[kind] : d12[kind]);
  endfunction

  function automatic logic [31:0] exp_lvl(int b);
    return ((m_lvl[b] & ~m_dir[b]) | (pins[32*b +: 32] & m_dir[b])) & IMPL[b];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  task automatic acc(input bit sm, input bit wr, input bit pm, input logic [6:0] a,
                     input logic [31:0] d, output logic [31:0] r);
    @(negedge clk);
    acc_write = wr; acc_pm = pm; acc_addr = a; acc_wdata = d;
    valid_m = !sm; valid_s = sm;
    @(negedge clk);
    valid_m = 0; valid_s = 0;
    r = sm ? rd_s : rd_m;
    if (!wr) chk("R2 rd_valid", {31'b0, sm ? rdv_s : rdv_m}, 32'd1);
  endtask

  task automatic wr_reg(int kind, int b, logic [31:0] d);
    logic [31:0] dummy;
    acc(0, 1, 0, ofs(kind, b), d, dummy);
    if (kind == 0 && func_en) m_use[b] = d & IMPL[b];
    if (kind == 1) m_dir[b] = ((d & ~OUTO[b]) | INO[b]) & IMPL[b];
    if (kind == 2) m_lvl[b] = d & IMPL[b];
  endtask

  task automatic check_pins(string req);
    logic [95:0] oe_pad, out_pad;
    oe_pad = {20'b0, poe_m};
    out_pad = {20'b0, pout_m};
    for (int b = 0; b < 3; b++) begin
      chk(req, oe_pad[32*b +: 32], func_en ? (m_use[b] & ~m_dir[b] & IMPL[b]) : 32'h0);
      chk(req, out_pad[32*b +: 32], m_lvl[b]);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nerr++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    for (int b = 0; b < 3; b++) begin
      m_use[b] = URST[b] & IMPL[b];
      m_dir[b] = ((IMPL[b] & ~OUTO[b]) | INO[b]) & IMPL[b];
      m_lvl[b] = '0;
    end
    repeat (5) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    for (int b = 0; b < 3; b++) begin
      acc(0, 0, 0, ofs(0, b), 0, q); chk("R1 use reset", q, m_use[b]);
      acc(0, 0, 0, ofs(1, b), 0, q); chk("R1 dir reset", q, m_dir[b]);
      acc(0, 0, 0, ofs(2, b), 0, q); chk("R1 lvl reset", q, 32'h0);
    end
    acc(0, 0, 1, 7'h28, 0, q); chk("R1 flags reset", q, 32'h0);
    check_pins("R1 pins reset");

    // R2 R3 R4 R5: pattern sweep over all nine registers
    foreach (PATS[p]) begin
      for (int b = 0; b < 3; b++)
        for (int k = 0; k < 3; k++) begin
          wr_reg(k, b, PATS[p] ^ (32'h0101_0101 * (b + 1)));
          acc(0, 0, 0, ofs(k, b), 0, q);
          chk("R2 R3 R4 readback", q, (k == 0) ? m_use[b] : (k == 1) ? m_dir[b] : exp_lvl(b));
        end
      check_pins("R5 pin drive");
    end

    // R6: input reads through synchronizer, output pins return stored level
    for (int b = 0; b < 3; b++) wr_reg(1, b, 32'hFFFF_FFFF);
    @(negedge clk); pins = {20'h0, 12'hA5C, 32'hDEAD_BEEF, 32'h1357_2468};
    repeat (3) @(negedge clk);
    for (int b = 0; b < 3; b++) begin
      acc(0, 0, 0, ofs(2, b), 0, q); chk("R6 input level", q, exp_lvl(b));
    end
    for (int b = 0; b < 3; b++) begin
      wr_reg(1, b, 32'h0000_FFFF);
      wr_reg(2, b, 32'h0F0F_3C3C);
      acc(0, 0, 0, ofs(2, b), 0, q); chk("R6 mixed level", q, exp_lvl(b));
    end
    check_pins("R5 mixed drive");

    // R7: change flags on low sixteen inputs only
    acc(0, 1, 1, 7'h28, 32'hFFFF_0000, q);
    acc(0, 0, 1, 7'h28, 0, q); chk("R8 clear all", q, 32'h0);
    @(negedge clk); pins[2] = ~pins[2]; pins[15] = ~pins[15]; pins[20] = ~pins[20];
    repeat (4) @(negedge clk);
    acc(0, 0, 1, 7'h28, 0, q); chk("R7 flags set", q, 32'h8004_0000);
    acc(0, 0, 1, 7'h2C, 0, q); chk("R7 other pm offset", q, 32'h0);

    // R8: write-1-to-clear and set-over-clear
    acc(0, 1, 1, 7'h28, 32'h0004_FFFF, q);
    acc(0, 0, 1, 7'h28, 0, q); chk("R8 partial clear", q, 32'h8000_0000);
    @(negedge clk); pins[7] = ~pins[7];
    @(negedge clk);
    acc(0, 1, 1, 7'h28, 32'h0080_0000, q);
    acc(0, 0, 1, 7'h28, 0, q); chk("R8 set wins", q, 32'h8080_0000);
    acc(0, 1, 1, 7'h28, 32'h8080_0000, q);
    acc(0, 0, 1, 7'h28, 0, q); chk("R8 cleared", q, 32'h0);

    // R9: disable gates outputs and freezes use-select
    wr_reg(1, 0, 32'h0);
    @(negedge clk); func_en = 0;
    #1 check_pins("R9 oe off");
    wr_reg(0, 0, 32'h0000_0000);
    acc(0, 0, 0, ofs(0, 0), 0, q); chk("R9 use frozen", q, m_use[0]);
    @(negedge clk); func_en = 1;
    #1 check_pins("R9 re-enabled");

    // R10: 64-byte window on the 20-pin instance, R4 unimplemented bits
    acc(1, 1, 0, 7'h44, 32'hFFFF_1234, q);
    acc(1, 0, 0, 7'h04, 0, q); chk("R10 alias dir", q, 32'h000F_1234);
    acc(1, 1, 0, 7'h40, 32'hFFF0_0000, q);
    acc(1, 0, 0, 7'h00, 0, q); chk("R10 R4 alias use", q, 32'h0);
    acc(0, 0, 0, 7'h44, 0, q); chk("R10 wide window", q, m_dir[2]);

    finish_run();
  end
endmodule